// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block is a register-programmed SPI master that runs exactly one serial-flash transaction each time software writes a start command. A transaction is assembled from phases: an 8-bit opcode that is always sent, an optional 3- or 4-byte address, and an optional data stream. The stream either goes out of a small local byte buffer or comes back into it. A seventh transaction shape repeatedly reads the flash status byte until the busy bit clears, or until a programmable poll budget runs out.

Software fills the opcode, address, length, clock divider and poll-limit registers. It then writes the control register with the start bit and a shape code, and polls the end flag. The serial interface is fixed to chip select active low, most significant bit first, clock idle low, data launched while the clock is low, and input sampled half a clock period after the rising edge (on the falling edge). All registers sit behind a flat byte-wide register port. Reads of that port are combinational.

Top module: `sfx_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, every register reads 0, and every buffer entry reads 0.
- R2: Every byte on spi_mosi goes out most significant bit first. SCK idles low, and spi_mosi only changes while SCK is low, so the flash can sample on the rising edge. The opcode register (offset 0x01) is always the first byte of a frame.
- R3: Shape codes 1, 3 and 5 send an address after the opcode. The width register (offset 0x06, bit 0) selects the address width: 0 sends 3 bytes, 1 sends 4 bytes. The address byte at offset 0x02 is the least significant, and offsets 0x03, 0x04 and 0x05 follow in rising significance. The most significant byte that is used goes out first.
- R4: Shape codes 2 (opcode then data-out) and 3 (opcode, address, data-out) send LEN bytes. LEN is offset 0x07 (low byte) plus offset 0x08 (high byte). Data byte k is taken from buffer entry k mod 8, and the buffer starts at offset 0x10. A one-byte write therefore always sends entry 0.
- R5: Shape codes 4 (opcode then data-in) and 5 (opcode, address, data-in) clock out LEN bytes and store data byte k into buffer entry k mod 8. MISO is sampled on the SCK falling edge.
- R6: Shape codes 0 and 1 send no data bytes, whatever LEN holds. A data shape with LEN equal to 0 also sends no data bytes and leaves the buffer unchanged.
- R7: Each SCK level lasts DIV+1 clock cycles. DIV is offset 0x09 (low byte) plus offset 0x0A (high byte).
- R8: The control/status register is at offset 0x00. A write with bit 7 set and shape code [2:0] starts a transaction. On read, the register shows bit 7 busy, bit 6 end, bit 5 error, and [2:0] the last accepted shape. The end flag clears when a transaction starts and sets when it completes. At completion busy falls and spi_cs_n returns to 1.
- R9: Shape code 6 repeats frames. Each frame is the opcode followed by one status byte read. Frames continue until bit 0 of the status byte is 0. spi_cs_n stays high for at least 2*(DIV+1) cycles between frames. On completion the end flag sets and the error flag stays clear.
- R10: The poll-limit register is at offset 0x0B and holds a value L (0 is treated as 1). If L status reads in shape 6 all report busy, the engine stops with both end and error set.
- R11: A start write while a transaction is in progress is ignored. The running transaction and its shape code are unchanged, and no extra frame follows.
- R12: Shape code 7 is reserved. A start with this code is ignored: no frame, and status unchanged.
- R13: spi_cs_n stays low without a break from the first opcode bit to the last bit of a frame. Outside a frame SCK does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Suppose the sequencer takes a wrong turn between phases, or miscounts the address or data index. The byte stream seen inside one chip-select frame then has the wrong length or content. This shows at the serial pins within one byte time (16*(DIV+1) cycles), and the end flag arrives early or late. If the buffer index or the receive path is wrong, the bad value surfaces at the register port as soon as the transaction ends. A poll loop with a broken gap, exit or budget shows up as the wrong number of chip-select frames and the wrong error flag.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
    localparam int LEN_W      = 16;
    localparam int DIV_W      = 16;
    localparam int ADR_MAX    = 4;
    localparam int RA_W       = 5;
    localparam int GO_BIT     = 7;
    localparam int FL_BUSY_BIT = 0;

    localparam logic [RA_W-1:0] RA_CTRL   = 5'h00;
    localparam logic [RA_W-1:0] RA_OPC    = 5'h01;
    localparam logic [RA_W-1:0] RA_ADR0   = 5'h02;
    localparam logic [RA_W-1:0] RA_ADR1   = 5'h03;
    localparam logic [RA_W-1:0] RA_ADR2   = 5'h04;
    localparam logic [RA_W-1:0] RA_ADR3   = 5'h05;
    localparam logic [RA_W-1:0] RA_WIDE   = 5'h06;
    localparam logic [RA_W-1:0] RA_LEN_LO = 5'h07;
    localparam logic [RA_W-1:0] RA_LEN_HI = 5'h08;
    localparam logic [RA_W-1:0] RA_DIV_LO = 5'h09;
    localparam logic [RA_W-1:0] RA_DIV_HI = 5'h0A;
    localparam logic [RA_W-1:0] RA_PLIM   = 5'h0B;

    typedef struct packed {
        logic valid;
        logic use_addr;
        logic send;
        logic recv;
        logic poll;
    } shape_t;

    typedef enum logic [1:0] {PH_OP, PH_ADR, PH_DAT} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_GAP} seq_st_e;

    function automatic shape_t decode_shape(input logic [2:0] code);
        shape_t s;
        s = '0;
        s.valid    = (code != 3'd7);
        s.use_addr = (code == 3'd1) || (code == 3'd3) || (code == 3'd5);
        s.send     = (code == 3'd2) || (code == 3'd3);
        s.recv     = (code == 3'd4) || (code == 3'd5);
        s.poll     = (code == 3'd6);
        return s;
    endfunction
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
    import sfx_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_we,
    input  logic [RA_W-1:0]             host_addr,
    input  logic [7:0]                  host_wdata,
    input  logic [7:0]                  status_byte,
    input  logic                        eng_we,
    input  logic [BUF_AW-1:0]           eng_widx,
    input  logic [7:0]                  eng_wdata,
    input  logic [BUF_AW-1:0]           eng_ridx,
    output logic [7:0]                  host_rdata,
    output logic [7:0]                  eng_rdata,
    output logic [7:0]                  opcode,
    output logic [ADR_MAX-1:0][7:0]     addr_bytes,
    output logic                        wide,
    output logic [LEN_W-1:0]            len,
    output logic [DIV_W-1:0]            div,
    output logic [7:0]                  poll_lim,
    output logic                        start_req,
    output logic [2:0]                  start_code
);
    logic [7:0] mem [BUF_DEPTH];
    logic       in_adr_win;

    assign in_adr_win = (host_addr >= RA_ADR0) && (host_addr <= RA_ADR3);

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode     <= '0;
            addr_bytes <= '0;
            wide       <= 1'b0;
            len        <= '0;
            div        <= '0;
            poll_lim   <= '0;
            for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
        end else begin
            if (host_we) begin
                if (in_adr_win)
                    addr_bytes[2'(host_addr - RA_ADR0)] <= host_wdata;
                case (host_addr)
                    RA_OPC:    opcode      <= host_wdata;
                    RA_WIDE:   wide        <= host_wdata[0];
                    RA_LEN_LO: len[7:0]    <= host_wdata;
                    RA_LEN_HI: len[15:8]   <= host_wdata;
                    RA_DIV_LO: div[7:0]    <= host_wdata;
                    RA_DIV_HI: div[15:8]   <= host_wdata;
                    RA_PLIM:   poll_lim    <= host_wdata;
                    default: ;
                endcase
            end
            // engine writes win over host writes to the buffer
            if (eng_we)
                mem[eng_widx] <= eng_wdata;
            else if (host_we && host_addr[RA_W-1])
                mem[host_addr[BUF_AW-1:0]] <= host_wdata;
        end
    end

    assign start_req  = host_we && (host_addr == RA_CTRL) && host_wdata[GO_BIT];
    assign start_code = host_wdata[2:0];
    assign eng_rdata  = mem[eng_ridx];

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr[RA_W-1]) begin
            host_rdata = mem[host_addr[BUF_AW-1:0]];
        end else if (in_adr_win) begin
            host_rdata = addr_bytes[2'(host_addr - RA_ADR0)];
        end else begin
            case (host_addr)
                RA_CTRL:   host_rdata = status_byte;
                RA_OPC:    host_rdata = opcode;
                RA_WIDE:   host_rdata = {7'd0, wide};
                RA_LEN_LO: host_rdata = len[7:0];
                RA_LEN_HI: host_rdata = len[15:8];
                RA_DIV_LO: host_rdata = div[7:0];
                RA_DIV_HI: host_rdata = div[15:8];
                RA_PLIM:   host_rdata = poll_lim;
                default:   host_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/sfx_byte_shifter.sv
module sfx_byte_shifter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             go,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx
);
    logic             active;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       nbit;
    logic [7:0]       sh;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            nbit   <= '0;
            sh     <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    nbit   <= '0;
                    sh     <= tx;
                    sck    <= 1'b0;
                end
            end else if (cnt == div) begin
                cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    // falling edge: sample half a period after the rise, launch next bit
                    sck <= 1'b0;
                    sh  <= {sh[6:0], miso};
                    if (nbit == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        rx     <= {sh[6:0], miso};
                    end else begin
                        nbit <= nbit + 3'd1;
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfx_sequencer.sv
module sfx_sequencer
    import sfx_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_req,
    input  logic [2:0]              start_code,
    input  logic [7:0]              opcode,
    input  logic [ADR_MAX-1:0][7:0] addr_bytes,
    input  logic                    wide,
    input  logic [LEN_W-1:0]        len,
    input  logic [DIV_W-1:0]        div,
    input  logic [7:0]              poll_lim,
    input  logic [7:0]              buf_rdata,
    input  logic                    sh_done,
    input  logic [7:0]              sh_rx,
    output logic                    sh_go,
    output logic [7:0]              sh_tx,
    output logic                    cs_n,
    output logic                    busy,
    output logic                    end_flag,
    output logic                    err_flag,
    output logic [2:0]              code_q,
    output logic [BUF_AW-1:0]       buf_ridx,
    output logic                    buf_we,
    output logic [BUF_AW-1:0]       buf_widx,
    output logic [7:0]              buf_wdata
);
    seq_st_e          st;
    phase_e           ph;
    logic [LEN_W-1:0] idx;
    shape_t           shp;
    shape_t           req_shp;
    logic [7:0]       polls;
    logic [DIV_W:0]   gap_cnt;
    logic [2:0]       nab;
    logic             last_addr;
    logic             data_pending;
    logic             lim_hit;

    assign req_shp      = decode_shape(start_code);
    assign nab          = wide ? 3'd4 : 3'd3;
    assign last_addr    = (idx[2:0] == nab - 3'd1);
    assign data_pending = shp.poll || ((shp.send || shp.recv) && (len != '0));
    assign lim_hit      = ({1'b0, polls} + 9'd1) >=
                          ((poll_lim == 8'd0) ? 9'd1 : {1'b0, poll_lim});

    always_comb begin
        case (ph)
            PH_OP:   sh_tx = opcode;
            PH_ADR:  sh_tx = addr_bytes[2'(nab - 3'd1 - idx[2:0])];
            default: sh_tx = shp.send ? buf_rdata : 8'h00;
        endcase
    end

    assign sh_go     = (st == ST_LOAD);
    assign busy      = (st != ST_IDLE);
    assign buf_ridx  = idx[BUF_AW-1:0];
    assign buf_widx  = idx[BUF_AW-1:0];
    assign buf_wdata = sh_rx;
    assign buf_we    = (st == ST_WAIT) && sh_done && (ph == PH_DAT) && shp.recv;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_OP;
            idx      <= '0;
            shp      <= '0;
            polls    <= '0;
            gap_cnt  <= '0;
            cs_n     <= 1'b1;
            end_flag <= 1'b0;
            err_flag <= 1'b0;
            code_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_req && req_shp.valid) begin
                        shp      <= req_shp;
                        code_q   <= start_code;
                        end_flag <= 1'b0;
                        err_flag <= 1'b0;
                        polls    <= '0;
                        cs_n     <= 1'b0;
                        ph       <= PH_OP;
                        idx      <= '0;
                        st       <= ST_LOAD;
                    end
                end
                ST_LOAD: st <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        case (ph)
                            PH_OP: begin
                                idx <= '0;
                                if (shp.use_addr) begin
                                    ph <= PH_ADR; st <= ST_LOAD;
                                end else if (data_pending) begin
                                    ph <= PH_DAT; st <= ST_LOAD;
                                end else begin
                                    cs_n <= 1'b1; end_flag <= 1'b1; st <= ST_IDLE;
                                end
                            end
                            PH_ADR: begin
                                if (!last_addr) begin
                                    idx <= idx + 1'b1; st <= ST_LOAD;
                                end else if (data_pending) begin
                                    idx <= '0; ph <= PH_DAT; st <= ST_LOAD;
                                end else begin
                                    cs_n <= 1'b1; end_flag <= 1'b1; st <= ST_IDLE;
                                end
                            end
                            default: begin
                                if (shp.poll) begin
                                    if (!sh_rx[FL_BUSY_BIT] || lim_hit) begin
                                        cs_n     <= 1'b1;
                                        end_flag <= 1'b1;
                                        err_flag <= sh_rx[FL_BUSY_BIT];
                                        st       <= ST_IDLE;
                                    end else begin
                                        polls   <= polls + 8'd1;
                                        cs_n    <= 1'b1;
                                        gap_cnt <= '0;
                                        st      <= ST_GAP;
                                    end
                                end else if (idx == len - 1'b1) begin
                                    cs_n <= 1'b1; end_flag <= 1'b1; st <= ST_IDLE;
                                end else begin
                                    idx <= idx + 1'b1; st <= ST_LOAD;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (gap_cnt == {div, 1'b1}) begin
                        cs_n <= 1'b0;
                        ph   <= PH_OP;
                        idx  <= '0;
                        st   <= ST_LOAD;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
    import sfx_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    localparam int BUF_AW = $clog2(BUF_DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    logic [7:0]              opcode;
    logic [ADR_MAX-1:0][7:0] addr_bytes;
    logic                    wide;
    logic [LEN_W-1:0]        len;
    logic [DIV_W-1:0]        div;
    logic [7:0]              poll_lim;
    logic                    start_req;
    logic [2:0]              start_code;
    logic [7:0]              eng_rdata;
    logic                    eng_we;
    logic [BUF_AW-1:0]       eng_widx;
    logic [BUF_AW-1:0]       eng_ridx;
    logic [7:0]              eng_wdata;
    logic                    sh_go;
    logic                    sh_done;
    logic [7:0]              sh_tx;
    logic [7:0]              sh_rx;
    logic                    seq_busy;
    logic                    seq_end;
    logic                    seq_err;
    logic [2:0]              seq_code;
    logic [7:0]              status_byte;

    assign status_byte = {seq_busy, seq_end, seq_err, 2'b00, seq_code};

    sfx_regs #(.BUF_DEPTH(BUF_DEPTH)) u_regs (
        .clk(clk), .rst(rst),
        .host_we(reg_we), .host_addr(reg_addr), .host_wdata(reg_wdata),
        .status_byte(status_byte),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .eng_ridx(eng_ridx),
        .host_rdata(reg_rdata), .eng_rdata(eng_rdata),
        .opcode(opcode), .addr_bytes(addr_bytes), .wide(wide),
        .len(len), .div(div), .poll_lim(poll_lim),
        .start_req(start_req), .start_code(start_code)
    );

    sfx_sequencer #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk(clk), .rst(rst),
        .start_req(start_req), .start_code(start_code),
        .opcode(opcode), .addr_bytes(addr_bytes), .wide(wide),
        .len(len), .div(div), .poll_lim(poll_lim),
        .buf_rdata(eng_rdata),
        .sh_done(sh_done), .sh_rx(sh_rx),
        .sh_go(sh_go), .sh_tx(sh_tx),
        .cs_n(spi_cs_n), .busy(seq_busy),
        .end_flag(seq_end), .err_flag(seq_err), .code_q(seq_code),
        .buf_ridx(eng_ridx), .buf_we(eng_we),
        .buf_widx(eng_widx), .buf_wdata(eng_wdata)
    );

    sfx_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst(rst), .div(div),
        .go(sh_go), .tx(sh_tx), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi),
        .done(sh_done), .rx(sh_rx)
    );
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic end_flag,
    input logic err_flag
);
    // R2: data launches only while SCK is low
    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R13: SCK pulses only inside a chip-select frame
    a_r13_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);

    // R8: an idle engine leaves the flash deselected
    a_r8_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R8: completion always raises the end flag
    a_r8_end_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> end_flag);

    // R10: the error flag never appears without the end flag
    a_r10_err_with_end: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> end_flag);

    // R8: a transaction in flight never shows the end flag
    a_r8_no_end_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !end_flag);
endmodule

bind sfx_engine sfx_checker u_sfx_checker (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .busy(seq_busy), .end_flag(seq_end), .err_flag(seq_err)
);

// File: tb/sfx_engine_bench.sv
module sfx_engine_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       miso_q = 1'b0;

    always #5 clk = ~clk;

    sfx_engine u_sfx_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(miso_q)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // ---------------- flash model ----------------
    int         nframes = 0, rises = 0, nbytes = 0;
    logic [7:0] sh_in = '0;
    logic [7:0] cap [64];
    bit         poll_mode = 0;
    int         busy_frames = 0, frame_base = 0;
    logic       prev_cs = 1'b1, prev_sck = 1'b0;

    function automatic logic [7:0] data_resp(input int b);
        return 8'h5A ^ 8'(b * 29);
    endfunction

    function automatic logic [7:0] model_byte(input int b);
        if (poll_mode)
            return (b == 1) ? (((nframes - frame_base) <= busy_frames) ? 8'h03 : 8'h02) : 8'h00;
        return data_resp(b);
    endfunction

    always @(spi_cs_n or spi_sck) begin
        if (prev_cs && !spi_cs_n) begin
            nframes = nframes + 1;
            rises = 0;
            nbytes = 0;
            miso_q = model_byte(0)[7];
        end else if (!spi_cs_n && spi_sck && !prev_sck) begin
            sh_in = {sh_in[6:0], spi_mosi};
            rises = rises + 1;
            if (rises % 8 == 0) begin
                if (nbytes < 64) cap[nbytes] = sh_in;
                nbytes = nbytes + 1;
            end
        end else if (!spi_cs_n && !spi_sck && prev_sck) begin
            miso_q = model_byte(rises / 8)[7 - (rises % 8)];
        end
        prev_cs = spi_cs_n;
        prev_sck = spi_sck;
    end

    // ---------------- clocked monitors and watchdog ----------------
    int cyc = 0, sck_run = 0, last_sck_hi = 0, cs_run = 0, last_gap = 0;

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (spi_sck) sck_run = sck_run + 1;
        else begin
            if (sck_run != 0) last_sck_hi = sck_run;
            sck_run = 0;
        end
        if (spi_cs_n) cs_run = cs_run + 1;
        else begin
            if (cs_run != 0) last_gap = cs_run;
            cs_run = 0;
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            report();
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle;
        logic [7:0] s;
        int t;
        t = 0;
        do begin rd(5'h00, s); t++; end while (s[7] && t < 40000);
    endtask

    task automatic run(input logic [2:0] code);
        wr(5'h00, 8'h80 | {5'd0, code});
        wait_idle();
    endtask

    logic [7:0] opc;
    logic [7:0] v;
    logic [7:0] exp_buf [8];
    int f0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 sck", int'(spi_sck), 0);
        rd(5'h00, v); chk("R1 status", v, 0);
        rd(5'h13, v); chk("R1 buffer", v, 0);

        opc = 8'h3B;
        wr(5'h01, opc);
        wr(5'h02, 8'h11); wr(5'h03, 8'h22); wr(5'h04, 8'h33); wr(5'h05, 8'h44);
        for (int j = 0; j < 8; j++) wr(5'h10 + 5'(j), 8'hC0 + 8'(j));
        wr(5'h07, 8'd5); wr(5'h08, 8'd0);

        // R2 R6 R8 R13: opcode only, LEN ignored
        f0 = nframes;
        run(3'd0);
        chk("R13 one frame (shape 0)", nframes - f0, 1);
        chk("R6 shape 0 byte count", nbytes, 1);
        chk("R2 opcode byte", cap[0], opc);
        rd(5'h00, v); chk("R8 status after shape 0", v, 8'h40);
        chk("R8 cs released", int'(spi_cs_n), 1);

        // R3: 24-bit address
        run(3'd1);
        chk("R6 shape 1 byte count", nbytes, 4);
        chk("R3 a24 byte1", cap[1], 8'h33);
        chk("R3 a24 byte2", cap[2], 8'h22);
        chk("R3 a24 byte3", cap[3], 8'h11);

        // R3: 32-bit address
        wr(5'h06, 8'h01);
        run(3'd1);
        chk("R3 a32 byte count", nbytes, 5);
        for (int k = 0; k < 4; k++) chk("R3 a32 order", cap[1 + k], 8'h44 - 8'(k * 8'h11));
        wr(5'h06, 8'h00);

        // R4: single byte write comes from entry 0
        wr(5'h07, 8'd1);
        run(3'd2);
        chk("R4 single byte count", nbytes, 2);
        chk("R4 single byte entry 0", cap[1], 8'hC0);

        // R4: address + 11 data bytes, wrapping buffer
        wr(5'h07, 8'd11);
        f0 = nframes;
        run(3'd3);
        chk("R13 one frame (shape 3)", nframes - f0, 1);
        chk("R4 write byte count", nbytes, 15);
        for (int k = 0; k < 11; k++) chk("R4 write data", cap[4 + k], 8'hC0 + 8'(k % 8));

        // R5: 5-byte read, no address
        wr(5'h07, 8'd5);
        run(3'd4);
        chk("R5 read byte count", nbytes, 6);
        for (int j = 0; j < 8; j++) begin
            rd(5'h10 + 5'(j), v);
            chk("R5 read buffer", v, (j < 5) ? data_resp(1 + j) : (8'hC0 + 8'(j)));
        end

        // R5: 32-bit address, 12-byte read wraps buffer
        wr(5'h06, 8'h01);
        wr(5'h07, 8'd12);
        run(3'd5);
        chk("R5 addr read byte count", nbytes, 17);
        for (int j = 0; j < 8; j++) begin
            exp_buf[j] = data_resp(5 + ((j + 8 < 12) ? j + 8 : j));
            rd(5'h10 + 5'(j), v);
            chk("R5 wrapped buffer", v, exp_buf[j]);
        end
        wr(5'h06, 8'h00);

        // R6: data shape with LEN 0 moves nothing
        wr(5'h07, 8'd0);
        run(3'd4);
        chk("R6 len0 byte count", nbytes, 1);
        rd(5'h10, v); chk("R6 len0 buffer kept", v, exp_buf[0]);

        // R7: divider 2 gives 3-cycle SCK levels
        wr(5'h09, 8'd2);
        run(3'd0);
        chk("R7 sck high cycles", last_sck_hi, 3);

        // R9: poll until ready after 3 busy reads
        opc = 8'h05;
        wr(5'h01, opc);
        wr(5'h0B, 8'd10);
        poll_mode = 1; busy_frames = 3; frame_base = nframes;
        f0 = nframes;
        run(3'd6);
        chk("R9 poll frames", nframes - f0, 4);
        chk("R9 poll frame bytes", nbytes, 2);
        chk("R9 poll opcode", cap[0], opc);
        rd(5'h00, v); chk("R9 status ok", v, 8'h46);
        chk("R9 cs gap >= 6", int'(last_gap >= 6), 1);

        // R10: budget of 2 exhausted
        wr(5'h0B, 8'd2);
        busy_frames = 1000; frame_base = nframes;
        f0 = nframes;
        run(3'd6);
        chk("R10 frames at limit 2", nframes - f0, 2);
        rd(5'h00, v); chk("R10 status error", v, 8'h66);

        // R10: limit 0 acts as 1
        wr(5'h0B, 8'd0);
        frame_base = nframes;
        f0 = nframes;
        run(3'd6);
        chk("R10 frames at limit 0", nframes - f0, 1);
        rd(5'h00, v); chk("R10 status error limit 0", v, 8'h66);

        // R8: new start clears end and error
        poll_mode = 0;
        wr(5'h00, 8'h80);
        rd(5'h00, v); chk("R8 end cleared on start", v & 8'hE0, 8'h80);
        wait_idle();

        // R11: start while busy is ignored
        wr(5'h07, 8'd3);
        f0 = nframes;
        wr(5'h00, 8'h83);
        repeat (20) @(negedge clk);
        wr(5'h00, 8'h80);
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R11 single frame", nframes - f0, 1);
        chk("R11 bytes of first shape", nbytes, 7);
        rd(5'h00, v); chk("R11 shape kept", v, 8'h43);

        // R12: reserved shape ignored
        f0 = nframes;
        wr(5'h00, 8'h87);
        rd(5'h00, v); chk("R12 status unchanged", v, 8'h43);
        repeat (40) @(negedge clk);
        chk("R12 no frame", nframes - f0, 0);
        chk("R12 cs idle", int'(spi_cs_n), 1);

        finished = 1;
        report();
        $finish;
    end
endmodule